// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler with Grouped Execution Units

This block is the issue stage of an out-of-order core. Decoded instructions arrive one per cycle from the dispatch stage and carry a destination tag, up to two source tags with per-source ready flags, the resource group they execute on, a result latency and a resource-cycle count. Each accepted instruction takes a slot in a bounded queue. It waits there until every source has been produced. A produced source is signalled by a tag broadcast. Once all sources are present the instruction becomes ready. Each resource group issues its oldest ready instruction to one of the group's execution units, and the unit is picked in round-robin order.

An issued instruction stays in its slot until its latency has elapsed. At that point a single write-back notification per cycle tells the retire stage that the instruction may retire, and the slot is released. When every slot is taken, the block raises a full indication towards dispatch. For performance analysis the block records the highest occupancy it has seen and a histogram of how many instructions issued in each cycle.

Top module: `ooo_sched`

## Requirements
- R1: An accepted instruction whose sources are all flagged ready is issued at the earliest in the cycle after the edge that accepts it. One whose sources are not all ready does not issue until they are.
- R2: A waiting instruction becomes eligible in the cycle after a broadcast of the tag it is missing. A broadcast in the same cycle as the dispatch that carries a matching source tag also counts.
- R3: Within one resource group, the oldest eligible instruction (the earliest accepted) issues first, whatever slot it sits in.
- R4: Each resource group issues at most one instruction per cycle, and different groups issue independently in the same cycle. iss_valid_o bit g flags group g, and its tag and unit sit in field g of iss_tag_o and iss_unit_o.
- R5: The unit search in a group starts at the group's pointer, skips busy units, and moves the pointer to the granted unit plus one, modulo the unit count. Every pointer is 0 after reset.
- R6: A granted unit stays busy for the resource-cycle count of the instruction, with a count of 0 treated as 1. An instruction waits while every unit of its group is busy.
- R7: An instruction issued in cycle t completes in cycle t+latency, with a latency of 0 treated as 1. Completions are reported one per cycle on wb_valid_o and wb_tag_o, oldest first, and a later completion is held until it is reported.
- R8: full_o is high while all QDEPTH slots are held. A dispatch in a cycle with full_o high is dropped.
- R9: max_occ_o holds the highest number of held slots seen over the cycles before the current one.
- R10: Field k of hist_o (bits k*CNTW upward) counts the cycles since reset in which exactly k instructions issued.
- R11: After reset the queue is empty: full_o, iss_valid_o, wb_valid_o, max_occ_o and hist_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| disp_valid_i | input | 1 | Dispatch request |
| disp_grp_i | input | GW | Resource group of the instruction |
| disp_dst_i | input | TAGW | Destination tag |
| disp_src_i | input | NSRC*TAGW | Source tags, source s in bits s*TAGW upward |
| disp_src_rdy_i | input | NSRC | Per-source operand-present flag |
| disp_lat_i | input | LATW | Result latency in cycles |
| disp_rc_i | input | RCW | Unit occupancy in cycles |
| bcast_valid_i | input | 1 | Result tag broadcast valid |
| bcast_tag_i | input | TAGW | Broadcast tag |
| full_o | output | 1 | All queue slots held |
| iss_valid_o | output | NGRP | Per-group issue grant |
| iss_tag_o | output | NGRP*TAGW | Destination tag of each group's issue |
| iss_unit_o | output | NGRP*UW | Unit granted within each group |
| wb_valid_o | output | 1 | Write-back notification to retire |
| wb_tag_o | output | TAGW | Destination tag completing |
| max_occ_o | output | OCCW | Peak occupancy observed |
| hist_o | output | (NGRP+1)*CNTW | Issues-per-cycle histogram |

## Verification
The hardest situation to reach is a younger instruction that sits in a lower slot than an older one, because slots fill from the lowest free index. The stimulus creates it by holding an older waiter in slot 1 while a long-latency instruction in slot 0 drains. A new younger waiter then takes slot 0, and one broadcast releases both waiters together. Two further sequences are arranged the same way: two groups wake on one broadcast, so their write-backs collide, and a group is driven so that its pointer lands on a busy unit.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    ST_FREE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_READY  = 2'd2,
    ST_ISSUED = 2'd3
  } ent_state_e;
endpackage

// File: rtl/sched_age_pick.sv
// One-hot pick of the oldest requester; age_i[j*N+i] = entry j older than entry i.
module sched_age_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0]   req_i,
  input  logic [N*N-1:0] age_i,
  output logic [N-1:0]   gnt_o,
  output logic           any_o
);
  logic [N-1:0] blocked;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < N; j++)
        blocked[i] = blocked[i] | (req_i[j] & age_i[j*N+i]);
      gnt_o[i] = req_i[i] & ~blocked[i];
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/sched_unit_pool.sv
module sched_unit_pool #(
  parameter int NU  = 2,
  parameter int RCW = 3,
  parameter int UW  = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_i,
  input  logic [RCW-1:0] rc_i,
  output logic           gnt_o,
  output logic [UW-1:0]  unit_o
);
  logic [RCW-1:0] busy_q [NU];
  logic [UW-1:0]  ptr_q;

  always_comb begin
    gnt_o  = 1'b0;
    unit_o = '0;
    for (int k = 0; k < NU; k++) begin
      if (req_i && !gnt_o && busy_q[UW'((int'(ptr_q) + k) % NU)] == '0) begin
        gnt_o  = 1'b1;
        unit_o = UW'((int'(ptr_q) + k) % NU);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int u = 0; u < NU; u++) busy_q[u] <= '0;
    end else begin
      for (int u = 0; u < NU; u++) begin
        if (gnt_o && unit_o == UW'(u))
          busy_q[u] <= (rc_i == '0) ? '0 : rc_i - 1'b1;
        else if (busy_q[u] != '0)
          busy_q[u] <= busy_q[u] - 1'b1;
      end
      if (gnt_o) ptr_q <= UW'((int'(unit_o) + 1) % NU);
    end
  end
endmodule

// File: rtl/sched_stats.sv
module sched_stats #(
  parameter int N    = 8,
  parameter int NGRP = 2,
  parameter int CNTW = 16,
  parameter int OCCW = 4,
  parameter int NIW  = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N-1:0]           held_i,
  input  logic [NIW-1:0]         n_iss_i,
  output logic [OCCW-1:0]        max_occ_o,
  output logic [(NGRP+1)*CNTW-1:0] hist_o
);
  logic [OCCW-1:0] occ;
  assign occ = OCCW'($countones(held_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      max_occ_o <= '0;
      hist_o    <= '0;
    end else begin
      if (occ > max_occ_o) max_occ_o <= occ;
      for (int b = 0; b <= NGRP; b++)
        if (n_iss_i == NIW'(b))
          hist_o[b*CNTW +: CNTW] <= hist_o[b*CNTW +: CNTW] + 1'b1;
    end
  end
endmodule

// File: rtl/ooo_sched.sv
module ooo_sched #(
  parameter int QDEPTH = 8,
  parameter int NGRP   = 2,
  parameter int NU     = 2,
  parameter int NSRC   = 2,
  parameter int TAGW   = 4,
  parameter int LATW   = 4,
  parameter int RCW    = 3,
  parameter int CNTW   = 16,
  localparam int GW    = (NGRP > 1) ? $clog2(NGRP) : 1,
  localparam int UW    = (NU > 1) ? $clog2(NU) : 1,
  localparam int OCCW  = $clog2(QDEPTH + 1),
  localparam int NIW   = $clog2(NGRP + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     disp_valid_i,
  input  logic [GW-1:0]            disp_grp_i,
  input  logic [TAGW-1:0]          disp_dst_i,
  input  logic [NSRC*TAGW-1:0]     disp_src_i,
  input  logic [NSRC-1:0]          disp_src_rdy_i,
  input  logic [LATW-1:0]          disp_lat_i,
  input  logic [RCW-1:0]           disp_rc_i,
  input  logic                     bcast_valid_i,
  input  logic [TAGW-1:0]          bcast_tag_i,
  output logic                     full_o,
  output logic [NGRP-1:0]          iss_valid_o,
  output logic [NGRP*TAGW-1:0]     iss_tag_o,
  output logic [NGRP*UW-1:0]       iss_unit_o,
  output logic                     wb_valid_o,
  output logic [TAGW-1:0]          wb_tag_o,
  output logic [OCCW-1:0]          max_occ_o,
  output logic [(NGRP+1)*CNTW-1:0] hist_o
);
  import sched_pkg::*;

  ent_state_e      state_q [QDEPTH];
  logic [GW-1:0]   grp_q   [QDEPTH];
  logic [TAGW-1:0] dst_q   [QDEPTH];
  logic [TAGW-1:0] src_q   [QDEPTH][NSRC];
  logic [NSRC-1:0] srdy_q  [QDEPTH];
  logic [LATW-1:0] lat_q   [QDEPTH];
  logic [RCW-1:0]  rc_q    [QDEPTH];
  logic [LATW-1:0] cnt_q   [QDEPTH];
  logic [QDEPTH-1:0] older_q [QDEPTH];

  logic [QDEPTH-1:0]        held, alloc_sel, issue_mask, wb_req, wb_sel;
  logic [QDEPTH*QDEPTH-1:0] age_flat;
  logic [NSRC-1:0]          in_match;
  logic [NSRC-1:0]          ent_match [QDEPTH];
  logic                     disp_acc, wb_any;

  always_comb begin
    for (int i = 0; i < QDEPTH; i++) begin
      held[i]   = (state_q[i] != ST_FREE);
      wb_req[i] = (state_q[i] == ST_ISSUED) && (cnt_q[i] == '0);
      for (int j = 0; j < QDEPTH; j++) age_flat[j*QDEPTH+i] = older_q[j][i];
      for (int s = 0; s < NSRC; s++)
        ent_match[i][s] = bcast_valid_i && (src_q[i][s] == bcast_tag_i);
    end
    for (int s = 0; s < NSRC; s++)
      in_match[s] = bcast_valid_i && (disp_src_i[s*TAGW +: TAGW] == bcast_tag_i);
  end

  // lowest free slot takes the incoming instruction
  always_comb begin
    alloc_sel = '0;
    for (int i = QDEPTH - 1; i >= 0; i--)
      if (!held[i]) alloc_sel = QDEPTH'(1) << i;
  end

  assign full_o   = &held;
  assign disp_acc = disp_valid_i && !full_o;

  // per-group oldest-ready pick and unit pool
  logic [QDEPTH-1:0] grp_iss [NGRP];
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [QDEPTH-1:0] req, sel;
    logic              any, gnt;
    logic [RCW-1:0]    rc_sel;
    logic [TAGW-1:0]   tag_sel;
    logic [UW-1:0]     unit;

    always_comb begin
      rc_sel  = '0;
      tag_sel = '0;
      for (int i = 0; i < QDEPTH; i++) begin
        req[i] = (state_q[i] == ST_READY) && (grp_q[i] == GW'(g));
        if (sel[i]) begin
          rc_sel  = rc_sel | rc_q[i];
          tag_sel = tag_sel | dst_q[i];
        end
      end
    end

    sched_age_pick #(.N(QDEPTH)) u_pick (
      .req_i(req), .age_i(age_flat), .gnt_o(sel), .any_o(any)
    );

    sched_unit_pool #(.NU(NU), .RCW(RCW), .UW(UW)) u_pool (
      .clk_i(clk_i), .rst_ni(rst_ni), .req_i(any), .rc_i(rc_sel),
      .gnt_o(gnt), .unit_o(unit)
    );

    assign grp_iss[g]                  = sel & {QDEPTH{gnt}};
    assign iss_valid_o[g]              = gnt;
    assign iss_tag_o[g*TAGW +: TAGW]   = tag_sel;
    assign iss_unit_o[g*UW +: UW]      = unit;
  end

  always_comb begin
    issue_mask = '0;
    for (int g = 0; g < NGRP; g++) issue_mask = issue_mask | grp_iss[g];
  end

  sched_age_pick #(.N(QDEPTH)) u_wb_pick (
    .req_i(wb_req), .age_i(age_flat), .gnt_o(wb_sel), .any_o(wb_any)
  );

  always_comb begin
    wb_tag_o = '0;
    for (int i = 0; i < QDEPTH; i++) if (wb_sel[i]) wb_tag_o = wb_tag_o | dst_q[i];
  end
  assign wb_valid_o = wb_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < QDEPTH; i++) begin
        state_q[i] <= ST_FREE;
        grp_q[i]   <= '0;
        dst_q[i]   <= '0;
        srdy_q[i]  <= '0;
        lat_q[i]   <= '0;
        rc_q[i]    <= '0;
        cnt_q[i]   <= '0;
        older_q[i] <= '0;
        for (int s = 0; s < NSRC; s++) src_q[i][s] <= '0;
      end
    end else begin
      for (int i = 0; i < QDEPTH; i++) begin
        if (disp_acc && alloc_sel[i]) begin
          grp_q[i]  <= disp_grp_i;
          dst_q[i]  <= disp_dst_i;
          srdy_q[i] <= disp_src_rdy_i | in_match;
          lat_q[i]  <= disp_lat_i;
          rc_q[i]   <= disp_rc_i;
          cnt_q[i]  <= '0;
          for (int s = 0; s < NSRC; s++) src_q[i][s] <= disp_src_i[s*TAGW +: TAGW];
          state_q[i] <= (&(disp_src_rdy_i | in_match)) ? ST_READY : ST_WAIT;
        end else begin
          unique case (state_q[i])
            ST_WAIT: begin
              srdy_q[i] <= srdy_q[i] | ent_match[i];
              if (&(srdy_q[i] | ent_match[i])) state_q[i] <= ST_READY;
            end
            ST_READY: if (issue_mask[i]) begin
              state_q[i] <= ST_ISSUED;
              cnt_q[i]   <= (lat_q[i] == '0) ? '0 : lat_q[i] - 1'b1;
            end
            ST_ISSUED: begin
              if (wb_sel[i])            state_q[i] <= ST_FREE;
              else if (cnt_q[i] != '0)  cnt_q[i]   <= cnt_q[i] - 1'b1;
            end
            default: ;
          endcase
        end
        // age matrix: row i / column i rewritten when slot i is allocated
        for (int j = 0; j < QDEPTH; j++) begin
          if (disp_acc && alloc_sel[j])      older_q[i][j] <= held[i] && (i != j);
          else if (disp_acc && alloc_sel[i]) older_q[i][j] <= 1'b0;
        end
      end
    end
  end

  sched_stats #(.N(QDEPTH), .NGRP(NGRP), .CNTW(CNTW), .OCCW(OCCW), .NIW(NIW)) u_stats (
    .clk_i(clk_i), .rst_ni(rst_ni), .held_i(held),
    .n_iss_i(NIW'($countones(iss_valid_o))),
    .max_occ_o(max_occ_o), .hist_o(hist_o)
  );
endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
  parameter int N    = 8,
  parameter int NGRP = 2,
  parameter int CNTW = 16,
  parameter int OCCW = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     full_o,
  input logic [OCCW-1:0]          max_occ_o,
  input logic [(NGRP+1)*CNTW-1:0] hist_o,
  input sched_pkg::ent_state_e    state_i [N]
);
  import sched_pkg::*;

  assert_occ_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_occ_o <= OCCW'(N)) && (max_occ_o >= $past(max_occ_o)));

  assert_full_peak_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |=> (max_occ_o == OCCW'(N)));

  for (genvar b = 0; b <= NGRP; b++) begin : g_hist
    assert_hist_mono_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hist_o[b*CNTW +: CNTW] >= $past(hist_o[b*CNTW +: CNTW]));
  end

  for (genvar i = 0; i < N; i++) begin : g_ent
    assert_issue_from_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_i[i] == ST_ISSUED) |->
        ($past(state_i[i]) == ST_READY || $past(state_i[i]) == ST_ISSUED));
    assert_wait_no_free_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_i[i] == ST_FREE && $past(state_i[i]) != ST_FREE) |->
        ($past(state_i[i]) == ST_ISSUED));
  end
endmodule

bind ooo_sched sched_chk #(.N(QDEPTH), .NGRP(NGRP), .CNTW(CNTW), .OCCW(OCCW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .full_o(full_o), .max_occ_o(max_occ_o),
  .hist_o(hist_o), .state_i(state_q)
);

// File: tb/ooo_sched_test.sv
module ooo_sched_test;
  localparam int QD = 8, NG = 2, TW = 4, CW = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic disp_valid, bcast_valid;
  logic [0:0] disp_grp;
  logic [3:0] disp_dst, disp_lat, bcast_tag;
  logic [7:0] disp_src;
  logic [1:0] disp_src_rdy;
  logic [2:0] disp_rc;
  logic full;
  logic [1:0] iss_valid, iss_unit;
  logic [7:0] iss_tag;
  logic wb_valid;
  logic [3:0] wb_tag, max_occ;
  logic [3*CW-1:0] hist;

  int n_chk = 0, n_bad = 0, n1 = 0, n2 = 0;

  always #5 clk = ~clk;

  ooo_sched uut (
    .clk_i(clk), .rst_ni(rst_ni), .disp_valid_i(disp_valid), .disp_grp_i(disp_grp),
    .disp_dst_i(disp_dst), .disp_src_i(disp_src), .disp_src_rdy_i(disp_src_rdy),
    .disp_lat_i(disp_lat), .disp_rc_i(disp_rc), .bcast_valid_i(bcast_valid),
    .bcast_tag_i(bcast_tag), .full_o(full), .iss_valid_o(iss_valid), .iss_tag_o(iss_tag),
    .iss_unit_o(iss_unit), .wb_valid_o(wb_valid), .wb_tag_o(wb_tag),
    .max_occ_o(max_occ), .hist_o(hist)
  );

  // grp[15:12] lat[11:8] rc[7:4] expected unit[3:0]
  localparam logic [15:0] VEC [7] = '{16'h0110, 16'h0311, 16'h1210, 16'h0010,
                                      16'h1511, 16'h1110, 16'h0421};

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input int g, input int dst, input int src, input int rdy,
                       input int lat, input int rc);
    disp_valid   = 1'b1;
    disp_grp     = 1'(g);
    disp_dst     = 4'(dst);
    disp_src     = {4'(src), 4'(src)};
    disp_src_rdy = 2'(rdy);
    disp_lat     = 4'(lat);
    disp_rc      = 3'(rc);
  endtask

  task automatic idle();
    disp_valid  = 1'b0;
    bcast_valid = 1'b0;
  endtask

  always @(negedge clk) if (rst_ni) begin
    if ($countones(iss_valid) == 1) n1++;
    if ($countones(iss_valid) == 2) n2++;
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int seen, lat_e;
    idle();
    drive(0, 0, 0, 3, 1, 1);
    disp_valid = 1'b0;
    bcast_tag  = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(full == 0 && iss_valid == 0 && wb_valid == 0, "R11 outputs", {full, iss_valid, wb_valid}, 0);
    chk(max_occ == 0 && hist == 0, "R11 stats", max_occ, 0);
    #2 rst_ni = 1'b1;
    @(negedge clk);

    // table walk: one instruction at a time (R1, R5, R7)
    for (int v = 0; v < 7; v++) begin
      int g, u;
      g = int'(VEC[v][15:12]); u = int'(VEC[v][3:0]);
      lat_e = (VEC[v][11:8] == 0) ? 1 : int'(VEC[v][11:8]);
      drive(g, v + 1, 0, 3, int'(VEC[v][11:8]), int'(VEC[v][7:4]));
      step();
      idle();
      chk(iss_valid == 2'(1 << g), "R1 issue next cycle", iss_valid, 1 << g);
      chk(int'(iss_unit[g]) == u, "R5 rr unit", iss_unit[g], u);
      chk(int'(iss_tag[g*TW +: TW]) == v + 1, "R4 issue tag", iss_tag[g*TW +: TW], v + 1);
      for (int d = 1; d <= lat_e; d++) begin
        step();
        if (d < lat_e) chk(wb_valid == 0, "R7 early wb", wb_valid, 0);
        else chk(wb_valid && wb_tag == 4'(v + 1), "R7 wb at latency", wb_tag, v + 1);
      end
      step();
    end
    chk(max_occ == 1, "R9 peak single", max_occ, 1);

    // oldest-first with the younger entry in the lower slot (R3, R2)
    drive(0, 3, 0, 3, 6, 1);
    step();
    drive(0, 4, 9, 0, 1, 1);
    step();
    idle();
    seen = 0;
    for (int k = 0; k < 8; k++) begin
      if (iss_valid[0] && iss_tag[3:0] == 4) seen = 1;
      step();
    end
    chk(seen == 0, "R1 waiter held", seen, 0);
    drive(0, 5, 9, 0, 1, 1);
    step();
    idle();
    bcast_valid = 1'b1; bcast_tag = 4'd9;
    chk(iss_valid == 0, "R2 no issue before wake", iss_valid, 0);
    step();
    idle();
    chk(iss_valid[0] && iss_tag[3:0] == 4, "R3 older first", iss_tag[3:0], 4);
    step();
    chk(iss_valid[0] && iss_tag[3:0] == 5, "R3 younger next", iss_tag[3:0], 5);
    repeat (4) step();

    // broadcast coinciding with dispatch, dual issue, write-back collision (R2, R4, R7)
    drive(0, 10, 13, 0, 2, 1);
    step();
    drive(1, 11, 13, 0, 2, 1);
    bcast_valid = 1'b1; bcast_tag = 4'd13;
    step();
    idle();
    chk(iss_valid == 2'b11, "R4 dual issue", iss_valid, 3);
    chk(iss_tag[7:4] == 11, "R2 same-cycle wake", iss_tag[7:4], 11);
    chk(iss_unit[1] == 1, "R5 group1 pointer", iss_unit[1], 1);
    step();
    chk(wb_valid == 0, "R7 not yet", wb_valid, 0);
    step();
    chk(wb_valid && wb_tag == 10, "R7 oldest wb first", wb_tag, 10);
    step();
    chk(wb_valid && wb_tag == 11, "R7 held wb", wb_tag, 11);
    repeat (3) step();

    // round robin skipping busy units and unit occupancy (R5, R6)
    drive(1, 1, 0, 3, 1, 4);
    step();
    chk(iss_valid[1] && iss_unit[1] == 0, "R5 first unit", iss_unit[1], 0);
    drive(1, 2, 0, 3, 1, 1);
    step();
    chk(iss_valid[1] && iss_unit[1] == 1, "R5 next unit", iss_unit[1], 1);
    drive(1, 3, 0, 3, 1, 3);
    step();
    chk(iss_valid[1] && iss_unit[1] == 1 && iss_tag[7:4] == 3, "R5 skip busy", iss_unit[1], 1);
    drive(1, 6, 0, 3, 1, 1);
    step();
    idle();
    chk(iss_valid[1] == 0, "R6 all units busy", iss_valid[1], 0);
    step();
    chk(iss_valid[1] && iss_unit[1] == 0 && iss_tag[7:4] == 6, "R6 unit freed", iss_unit[1], 0);
    repeat (4) step();

    // capacity and dropped dispatch (R8, R9)
    for (int k = 0; k < QD; k++) begin
      drive(0, k, 15, 0, 1, 1);
      step();
    end
    chk(full == 1, "R8 full raised", full, 1);
    drive(0, 8, 15, 0, 1, 1);
    step();
    idle();
    chk(full == 1, "R8 still full", full, 1);
    step();
    chk(max_occ == QD, "R9 peak", max_occ, QD);
    bcast_valid = 1'b1; bcast_tag = 4'd15;
    step();
    idle();
    seen = 0;
    for (int k = 0; k < 12; k++) begin
      if (iss_valid[0]) begin
        chk(int'(iss_tag[3:0]) == seen, "R3 drain order", iss_tag[3:0], seen);
        seen++;
      end
      step();
    end
    chk(seen == QD, "R8 dropped dispatch", seen, QD);
    chk(full == 0, "R8 full cleared", full, 0);

    // histogram (R10)
    @(posedge clk);
    #1;
    chk(int'(hist[1*CW +: CW]) == n1, "R10 bin1", hist[1*CW +: CW], n1);
    chk(int'(hist[2*CW +: CW]) == n2, "R10 bin2", hist[2*CW +: CW], n2);
    finish_run();
  end
endmodule